// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block runs the sixteen data-processing operations of a 32-bit load/store processor core. It takes a 4-bit operation code, a set-flags bit, a first operand, a second operand that an upstream barrel shifter has already produced, that shifter's carry-out, and the current N/Z/C/V flags. It returns the result, a destination-write strobe, the next flag values and a marker for codes it does not handle.

The operations fall into four groups: bitwise logic, add and subtract with or without carry-in, reverse subtract (operands swapped), and compare/test codes that change only the flags. For bitwise logic the new carry comes from the shifter, not the adder. When the second operand is an immediate whose rotate amount is zero, the shifter has no carry to give, and the upstream stage says so on a qualifier pin so that the old carry is kept.

Work enters on a valid/ready handshake and leaves one cycle later from a single output register that also uses valid/ready. A new input is accepted when the output register is empty, or when the output is consumed in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds steady and `in_ready` is low. Flag vectors use bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.

Top module: `dp_alu`

## Requirements
- R1: Logical codes give these results: 0x0 and 0x8 give A AND B, 0x1 and 0x9 give A XOR B, 0xC gives A OR B, 0xD gives B, 0xE gives A AND NOT B, 0xF gives NOT B.
- R2: Arithmetic codes give these results modulo 2^32, with C being flag bit 1: 0x2 and 0xA give A−B, 0x3 gives B−A, 0x4 and 0xB give A+B, 0x5 gives A+B+C, 0x6 gives A−B+C−1, 0x7 gives B−A+C−1.
- R3: An arithmetic code with set-flags high takes C from the 32-bit carry-out. For subtraction, C=1 means no borrow. V is signed overflow, worked out with the operands in the order the code uses them, so reverse forms use B as the minuend.
- R4: A logical code with set-flags high sets N to result bit 31 and Z to (result == 0), and keeps V. C becomes `in_shift_carry` when `in_shift_carry_used` is 1, and otherwise keeps its old value.
- R5: Codes 0x8 to 0xB with set-flags high update the flags as R3 or R4 describe. They hold `out_write` low, and `out_result` shows the computed value.
- R6: Codes 0x8 to 0xB with set-flags low raise `out_unhandled`, hold `out_write` low, return a zero result and pass the flags through unchanged.
- R7: With set-flags low, `out_flags` equals `in_flags`. Every handled code outside 0x8 to 0xB raises `out_write`.
- R8: An input accepted on a rising edge appears on the outputs after that edge. `in_ready` = !out_valid || out_ready. While a result is stalled, the outputs stay stable.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_op | input | 4 | Operation code |
| in_set_flags | input | 1 | Update the flags from this operation |
| in_opa | input | W | First operand |
| in_opb | input | W | Shifted second operand |
| in_shift_carry | input | 1 | Shifter carry-out |
| in_shift_carry_used | input | 1 | Shifter carry is meaningful (non-zero shift or rotate) |
| in_flags | input | 4 | Current N,Z,C,V |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | W | Operation result |
| out_write | output | 1 | Destination register should be written |
| out_flags | output | 4 | Next N,Z,C,V |
| out_unhandled | output | 1 | Code is not a data-processing operation |

## Verification
A bad decode entry shows up on the very next accepted operation with that code, as a wrong result, a stray write strobe, or a carry taken from the wrong source. Random codes reach every entry early in the run. A wrong operand swap or borrow convention shows only in C or V, so the directed cases force sign and borrow boundaries. A faulty output-register state shows during a stall: the held result changes, or a second input slips in while `in_ready` should be low.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_e;

  typedef struct packed {
    logic is_arith;
    logic subtract;
    logic swap;
    cin_e cin;
    logic write;
    logic unhandled;
  } ctl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/dpa_decode.sv
module dpa_decode
  import dpa_pkg::*;
(
  input  dp_op_e op,
  input  logic   set_flags,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '{is_arith: 1'b0, subtract: 1'b0, swap: 1'b0, cin: CIN_ZERO,
            write: 1'b1, unhandled: 1'b0};
    unique case (op)
      OP_SUB: begin ctl.is_arith = 1'b1; ctl.subtract = 1'b1; ctl.cin = CIN_ONE; end
      OP_RSB: begin ctl.is_arith = 1'b1; ctl.subtract = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_ONE; end
      OP_ADD: begin ctl.is_arith = 1'b1; end
      OP_ADC: begin ctl.is_arith = 1'b1; ctl.cin = CIN_FLAG; end
      OP_SBC: begin ctl.is_arith = 1'b1; ctl.subtract = 1'b1; ctl.cin = CIN_FLAG; end
      OP_RSC: begin ctl.is_arith = 1'b1; ctl.subtract = 1'b1; ctl.swap = 1'b1; ctl.cin = CIN_FLAG; end
      OP_TST, OP_TEQ: begin ctl.write = 1'b0; ctl.unhandled = !set_flags; end
      OP_CMP: begin
        ctl.is_arith = 1'b1; ctl.subtract = 1'b1; ctl.cin = CIN_ONE;
        ctl.write = 1'b0; ctl.unhandled = !set_flags;
      end
      OP_CMN: begin
        ctl.is_arith = 1'b1; ctl.write = 1'b0; ctl.unhandled = !set_flags;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dpa_logic.sv
module dpa_logic
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  dp_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/dpa_arith.sv
module dpa_arith
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         swap,
  input  cin_e         cin,
  input  logic         c_flag,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int WX = W + 1;
  logic [W-1:0] x, y_raw, y;
  logic         ci;
  logic [WX-1:0] full;

  always_comb begin
    x     = swap ? b : a;
    y_raw = swap ? a : b;
    y     = subtract ? ~y_raw : y_raw;
    unique case (cin)
      CIN_ONE:  ci = 1'b1;
      CIN_FLAG: ci = c_flag;
      default:  ci = 1'b0;
    endcase
    full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    sum   = full[W-1:0];
    carry = full[W];
    ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic         in_set_flags,
  input  logic [W-1:0] in_opa,
  input  logic [W-1:0] in_opb,
  input  logic         in_shift_carry,
  input  logic         in_shift_carry_used,
  input  logic [3:0]   in_flags,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_write,
  output logic [3:0]   out_flags,
  output logic         out_unhandled
);
  dp_op_e       op;
  ctl_t         ctl;
  logic [W-1:0] lres, ares, res;
  logic         acarry, aovf, fire;
  logic [3:0]   nflags;

  assign op = dp_op_e'(in_op);

  dpa_decode u_dec (.op(op), .set_flags(in_set_flags), .ctl(ctl));

  dpa_logic #(.W(W)) u_log (.op(op), .a(in_opa), .b(in_opb), .y(lres));

  dpa_arith #(.W(W)) u_ari (
    .a(in_opa), .b(in_opb), .subtract(ctl.subtract), .swap(ctl.swap),
    .cin(ctl.cin), .c_flag(in_flags[FLAG_C]),
    .sum(ares), .carry(acarry), .ovf(aovf)
  );

  always_comb begin
    res    = ctl.unhandled ? '0 : (ctl.is_arith ? ares : lres);
    nflags = in_flags;
    if (in_set_flags && !ctl.unhandled) begin
      nflags[FLAG_N] = res[W-1];
      nflags[FLAG_Z] = (res == '0);
      if (ctl.is_arith) begin
        nflags[FLAG_C] = acarry;
        nflags[FLAG_V] = aovf;
      end else if (in_shift_carry_used) begin
        nflags[FLAG_C] = in_shift_carry;
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_write     <= 1'b0;
      out_flags     <= '0;
      out_unhandled <= 1'b0;
    end else if (fire) begin
      out_valid     <= 1'b1;
      out_result    <= res;
      out_write     <= ctl.write;
      out_flags     <= nflags;
      out_unhandled <= ctl.unhandled;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)
                                && $stable(out_write));

  a_r8_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r7_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_set_flags |=> out_flags == $past(in_flags));

  a_r6_unhandled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unhandled |-> !out_write && out_result == '0);

  a_r5_nz_follow_result: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_set_flags && !ctl.unhandled |=>
      out_flags[FLAG_Z] == (out_result == '0) && out_flags[FLAG_N] == out_result[W-1]);

  a_r4_v_kept_on_logic: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctl.is_arith |=> out_flags[FLAG_V] == $past(in_flags[FLAG_V]));
endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        unh;
    logic        wr;
    logic [3:0]  fl;
    logic [31:0] res;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_set_flags = 1'b0, in_shift_carry = 1'b0;
  logic in_shift_carry_used = 1'b0, out_valid, out_ready = 1'b1, out_write, out_unhandled;
  logic [3:0] in_op = '0, in_flags = '0, out_flags;
  logic [31:0] in_opa = '0, in_opb = '0, out_result;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_set_flags(in_set_flags), .in_opa(in_opa), .in_opb(in_opb),
    .in_shift_carry(in_shift_carry), .in_shift_carry_used(in_shift_carry_used),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_write(out_write), .out_flags(out_flags),
    .out_unhandled(out_unhandled)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic s, input logic [31:0] a,
                                 input logic [31:0] b, input logic shc, input logic shu,
                                 input logic [3:0] fl);
    exp_t e;
    logic [31:0] x, y, r;
    logic [33:0] wide;
    logic arith, addk, cy, v, bi;
    logic c = fl[1];
    arith = 1'b0; addk = 1'b0; x = a; y = b; bi = 1'b0;
    case (op)
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC: r = a | b;
      4'hD: r = b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'h2, 4'hA: begin arith = 1; end
      4'h3: begin arith = 1; x = b; y = a; end
      4'h4, 4'hB: begin arith = 1; addk = 1; end
      4'h5: begin arith = 1; addk = 1; bi = c; end
      4'h6: begin arith = 1; bi = !c; end
      default: begin arith = 1; x = b; y = a; bi = !c; end
    endcase
    cy = 1'b0; v = 1'b0;
    if (arith) begin
      if (addk) begin
        wide = {2'b0, x} + {2'b0, y} + {33'b0, bi};
        r = wide[31:0]; cy = wide[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end else begin
        r = x - y - {31'b0, bi};
        cy = ({2'b0, x} >= ({2'b0, y} + {33'b0, bi}));
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
    end
    e.unh = (op[3:2] == 2'b10) && !s;
    e.wr  = !(op[3:2] == 2'b10);
    e.fl  = fl;
    e.res = e.unh ? 32'h0 : r;
    if (s && !e.unh) begin
      e.fl[3] = r[31];
      e.fl[2] = (r == 0);
      if (arith) begin e.fl[1] = cy; e.fl[0] = v; end
      else if (shu) e.fl[1] = shc;
    end
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic s, input logic [31:0] a,
                       input logic [31:0] b, input logic shc, input logic shu,
                       input logic [3:0] fl);
    in_op = op; in_set_flags = s; in_opa = a; in_opb = b;
    in_shift_carry = shc; in_shift_carry_used = shu; in_flags = fl;
  endtask

  task automatic run(input logic [3:0] op, input logic s, input logic [31:0] a,
                     input logic [31:0] b, input logic shc, input logic shu,
                     input logic [3:0] fl);
    exp_t e;
    string rt, ft;
    e = model(op, s, a, b, shc, shu, fl);
    if (op[3:2] == 2'b10) begin rt = s ? "R5" : "R6"; ft = s ? "R5" : "R6"; end
    else if (op[3:2] == 2'b11 || op[3:1] == 3'b000) begin rt = "R1"; ft = "R4"; end
    else begin rt = "R2"; ft = "R3"; end
    if (!s && op[3:2] != 2'b10) ft = "R7";
    @(negedge clk);
    drive(op, s, a, b, shc, shu, fl);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid", {63'b0, out_valid}, 64'd1);
    chk({rt, " result"}, {32'b0, out_result}, {32'b0, e.res});
    chk({ft, " flags"}, {60'b0, out_flags}, {60'b0, e.fl});
    chk((op[3:2] == 2'b10) ? "R5 write" : "R7 write", {63'b0, out_write}, {63'b0, e.wr});
    chk("R6 unhandled", {63'b0, out_unhandled}, {63'b0, e.unh});
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_t e1, e2;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R9 out_valid after reset", {63'b0, out_valid}, 64'd0);
    chk("R9 in_ready after reset", {63'b0, in_ready}, 64'd1);

    run(4'h4, 1, 32'h7FFF_FFFF, 32'h1, 0, 0, 4'h0);   // R3 V on add
    run(4'h2, 1, 32'h0, 32'h1, 0, 0, 4'h0);           // R3 borrow -> C=0
    run(4'h2, 1, 32'h5, 32'h5, 0, 0, 4'h0);           // R3 Z and C=1
    run(4'h3, 1, 32'h1, 32'h3, 0, 0, 4'h0);           // R2 reverse subtract
    run(4'h7, 1, 32'h1, 32'h3, 0, 0, 4'h0);           // R2 RSC with C=0
    run(4'hA, 1, 32'h8000_0000, 32'h1, 0, 0, 4'h0);   // R5 CMP overflow
    run(4'h6, 1, 32'h10, 32'h3, 0, 0, 4'h2);          // R2 SBC with C=1
    run(4'h5, 1, 32'hFFFF_FFFF, 32'h0, 0, 0, 4'h2);   // R3 ADC wraps
    run(4'hD, 1, 32'h0, 32'h8000_0000, 0, 0, 4'h3);   // R4 C kept
    run(4'hD, 1, 32'h0, 32'h0, 1, 1, 4'h1);           // R4 C from shifter
    run(4'h9, 0, 32'h1234, 32'h1234, 1, 1, 4'hA);     // R6 unhandled
    run(4'h8, 1, 32'hF0, 32'h0F, 0, 0, 4'h0);         // R5 TST
    run(4'hB, 1, 32'hFFFF_FFFF, 32'h1, 0, 0, 4'h0);   // R5 CMN carry
    run(4'hE, 0, 32'hFF, 32'h0F, 1, 1, 4'h5);         // R7 pass-through

    for (int i = 0; i < 600; i++)
      run(4'($urandom), 1'($urandom), $urandom, ($urandom % 4 == 0) ? 32'h0 : $urandom,
          1'($urandom), 1'($urandom), 4'($urandom));

    // R8 stall: first result must hold while a second input waits
    @(negedge clk);
    e1 = model(4'h4, 1, 32'd10, 32'd20, 0, 0, 4'h0);
    e2 = model(4'h2, 1, 32'd3, 32'd9, 0, 0, 4'h0);
    drive(4'h4, 1, 32'd10, 32'd20, 0, 0, 4'h0);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    drive(4'h2, 1, 32'd3, 32'd9, 0, 0, 4'h0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 in_ready low while stalled", {63'b0, in_ready}, 64'd0);
      chk("R8 held result", {32'b0, out_result}, {32'b0, e1.res});
      chk("R8 held flags", {60'b0, out_flags}, {60'b0, e1.fl});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result", {32'b0, out_result}, {32'b0, e2.res});
    chk("R8 second flags", {60'b0, out_flags}, {60'b0, e2.fl});
    @(negedge clk);
    chk("R8 drained", {63'b0, out_valid}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule